// File: doc/BRIEF.md
# PWM Channel Enable and Period Interrupt Controller

This block is the shared control layer that sits above the four counters of a multi-channel pulse-width modulator. It owns the on/off state of every channel and the interrupt mask of every channel. It collects the one-cycle period-end pulses that each running counter emits and turns them into sticky pending events. A single combined interrupt line tells software that a masked-in channel has finished a period. The counters themselves and the prescalers that feed them live outside this block.

Software reaches the block over a plain register bus. Writes are single-cycle strobes. A read strobe returns its data one cycle later, flagged by `rd_valid`. Channel on/off state and mask state are never written directly. A one written to a "set" offset turns a bit on, a one written to the matching "clear" offset turns it off, and zero bits leave the state alone. This lets several drivers share the block without read-modify-write races. The pending events are acknowledged by reading them. The bus carries no back-pressure: every strobe is accepted in the cycle it is presented, and there is no ready signal.

Top module: `pwmc_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, all channel enables, all mask bits and all pending events are zero and `irq` is low.
- R2: A write to offset 0x04 turns on every channel whose bit in `wr_bits` is 1, from the next cycle on; channels written with 0 keep their state.
- R3: A write to offset 0x08 turns off every channel whose bit in `wr_bits` is 1, from the next cycle on; channels written with 0 keep their state.
- R4: A read of offset 0x0C returns the enable state, with channel n in bit n and every higher bit zero.
- R5: A write to offset 0x10 sets, and a write to offset 0x14 clears, the mask bits whose `wr_bits` bit is 1. A read of offset 0x18 returns the mask, with channel n in bit n.
- R6: A `period_end` pulse on an enabled channel makes that channel's event pending. A pulse on a disabled channel is ignored.
- R7: A read of offset 0x1C returns the pending events, with channel n in bit n, and clears all of them in that same access.
- R8: A period-end pulse that arrives in the same cycle as a read of 0x1C is not part of the returned value, and it stays pending after the read.
- R9: `irq` is high exactly while at least one channel has both its pending event and its mask bit set.
- R10: Writes to offset 0x00 and to the read-only offsets 0x0C, 0x18 and 0x1C change no state. Reads of offset 0x00 and of any other unmapped offset return zero.
- R11: `rd_valid` is high in the cycle after `rd_en`, with `rdata` holding the requested value; the read data is held until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | ADDR_W (8) | Byte offset of the access |
| wr_bits | input | NUM_CH (4) | Write data, one bit per channel |
| period_end | input | NUM_CH (4) | Per-channel end-of-period pulse from the counters |
| rdata | output | DATA_W (32) | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | High one cycle after an accepted read |
| chan_en | output | NUM_CH (4) | Per-channel run enable to the counters |
| irq | output | 1 | Combined period interrupt |

## Verification
The hardest case to reach from the ports is the collision in which a counter's period-end pulse lands in the very cycle that software reads and acknowledges the pending events. It only arises when a read strobe and an event pulse are driven in the same clock. The bench builds it on purpose. It first drains all pending events, then presents the read of 0x1C together with a pulse on an enabled channel. It checks that the returned word does not show the new event and that a second read does show it. The masked-out variant of this case is also covered, where the new pending bit must not raise `irq`.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

  // Register offsets; software and the bench depend on these values.
  localparam int unsigned OFF_MODE   = 32'h00;
  localparam int unsigned OFF_EN_SET = 32'h04;
  localparam int unsigned OFF_EN_CLR = 32'h08;
  localparam int unsigned OFF_STATE  = 32'h0C;
  localparam int unsigned OFF_IM_SET = 32'h10;
  localparam int unsigned OFF_IM_CLR = 32'h14;
  localparam int unsigned OFF_IMASK  = 32'h18;
  localparam int unsigned OFF_EVENTS = 32'h1C;

  typedef enum logic [1:0] {
    RSEL_ZERO  = 2'd0,
    RSEL_STATE = 2'd1,
    RSEL_MASK  = 2'd2,
    RSEL_EVENT = 2'd3
  } rsel_e;

endpackage

// File: rtl/pwmc_w1_bank.sv
// One bit of state per channel, changed only by set and clear strobes.
module pwmc_w1_bank #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_stb,
  input  logic [NUM_CH-1:0] clr_stb,
  output logic [NUM_CH-1:0] state
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        state[g] <= 1'b0;
      end else if (set_stb[g]) begin
        state[g] <= 1'b1;
      end else if (clr_stb[g]) begin
        state[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pwmc_event_latch.sv
// Sticky per-channel period events; an acknowledge never drops a new event.
module pwmc_event_latch #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt,
  input  logic [NUM_CH-1:0] gate,
  input  logic              ack,
  output logic [NUM_CH-1:0] pending
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic arrive;
    assign arrive = evt[g] & gate[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pending[g] <= 1'b0;
      end else begin
        pending[g] <= (pending[g] & ~ack) | arrive;
      end
    end
  end

endmodule

// File: rtl/pwmc_decode.sv
// Address decode into per-channel set/clear strobes and a read selector.
module pwmc_decode
  import pwmc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NUM_CH-1:0] wr_bits,
  output logic [NUM_CH-1:0] en_set,
  output logic [NUM_CH-1:0] en_clr,
  output logic [NUM_CH-1:0] im_set,
  output logic [NUM_CH-1:0] im_clr,
  output logic              evt_ack,
  output rsel_e             rsel
);

  logic hit_en_set, hit_en_clr, hit_im_set, hit_im_clr;
  logic hit_state, hit_imask, hit_events;

  assign hit_en_set = (addr == ADDR_W'(OFF_EN_SET));
  assign hit_en_clr = (addr == ADDR_W'(OFF_EN_CLR));
  assign hit_im_set = (addr == ADDR_W'(OFF_IM_SET));
  assign hit_im_clr = (addr == ADDR_W'(OFF_IM_CLR));
  assign hit_state  = (addr == ADDR_W'(OFF_STATE));
  assign hit_imask  = (addr == ADDR_W'(OFF_IMASK));
  assign hit_events = (addr == ADDR_W'(OFF_EVENTS));

  assign en_set  = (wr_en && hit_en_set) ? wr_bits : '0;
  assign en_clr  = (wr_en && hit_en_clr) ? wr_bits : '0;
  assign im_set  = (wr_en && hit_im_set) ? wr_bits : '0;
  assign im_clr  = (wr_en && hit_im_clr) ? wr_bits : '0;
  assign evt_ack = rd_en && hit_events;

  always_comb begin
    if (hit_state)       rsel = RSEL_STATE;
    else if (hit_imask)  rsel = RSEL_MASK;
    else if (hit_events) rsel = RSEL_EVENT;
    else                 rsel = RSEL_ZERO;
  end

endmodule

// File: rtl/pwmc_rd_port.sv
// Registered read data path.
module pwmc_rd_port
  import pwmc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  rsel_e             rsel,
  input  logic [NUM_CH-1:0] en_state,
  input  logic [NUM_CH-1:0] im_state,
  input  logic [NUM_CH-1:0] ev_state,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid
);

  logic [NUM_CH-1:0] pick;

  always_comb begin
    unique case (rsel)
      RSEL_STATE: pick = en_state;
      RSEL_MASK:  pick = im_state;
      RSEL_EVENT: pick = ev_state;
      default:    pick = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= DATA_W'(pick);
    end
  end

endmodule

// File: rtl/pwmc_ctrl.sv
module pwmc_ctrl
  import pwmc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NUM_CH-1:0] wr_bits,
  input  logic [NUM_CH-1:0] period_end,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  output logic [NUM_CH-1:0] chan_en,
  output logic              irq
);

  logic [NUM_CH-1:0] en_set, en_clr, im_set, im_clr;
  logic [NUM_CH-1:0] mask_q, pend_q;
  logic              evt_ack;
  rsel_e             rsel;

  pwmc_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wr_bits (wr_bits),
    .en_set  (en_set),
    .en_clr  (en_clr),
    .im_set  (im_set),
    .im_clr  (im_clr),
    .evt_ack (evt_ack),
    .rsel    (rsel)
  );

  pwmc_w1_bank #(.NUM_CH(NUM_CH)) u_enable (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_stb (en_set),
    .clr_stb (en_clr),
    .state   (chan_en)
  );

  pwmc_w1_bank #(.NUM_CH(NUM_CH)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_stb (im_set),
    .clr_stb (im_clr),
    .state   (mask_q)
  );

  pwmc_event_latch #(.NUM_CH(NUM_CH)) u_events (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (period_end),
    .gate    (chan_en),
    .ack     (evt_ack),
    .pending (pend_q)
  );

  pwmc_rd_port #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rsel     (rsel),
    .en_state (chan_en),
    .im_state (mask_q),
    .ev_state (pend_q),
    .rdata    (rdata),
    .rd_valid (rd_valid)
  );

  assign irq = |(pend_q & mask_q);

endmodule

// File: rtl/pwmc_ctrl_chk.sv
module pwmc_ctrl_chk
  import pwmc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NUM_CH-1:0] wr_bits,
  input logic [NUM_CH-1:0] period_end,
  input logic              rd_valid,
  input logic [NUM_CH-1:0] chan_en,
  input logic              irq,
  input logic [NUM_CH-1:0] pend,
  input logic [NUM_CH-1:0] mask
);

  logic was_rst;
  always_ff @(posedge clk) was_rst <= !rst_n;

  always @(posedge clk) begin
    if (rst_n && was_rst) begin
      assert_reset_clear_R1: assert (chan_en == '0 && mask == '0 && pend == '0 && !irq);
    end
  end

  assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFF_EN_SET)) |=>
      ((chan_en & $past(wr_bits)) == $past(wr_bits)));

  assert_en_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFF_EN_CLR)) |=>
      ((chan_en & $past(wr_bits)) == '0));

  assert_en_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && (addr == ADDR_W'(OFF_EN_SET) || addr == ADDR_W'(OFF_EN_CLR)))) |=>
      $stable(chan_en));

  assert_mask_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFF_IM_SET)) |=>
      ((mask & $past(wr_bits)) == $past(wr_bits)));

  assert_mask_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFF_IM_CLR)) |=> ((mask & $past(wr_bits)) == '0));

  assert_evt_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((period_end & chan_en) != '0) |=>
      ((pend & $past(period_end & chan_en)) == $past(period_end & chan_en)));

  assert_ack_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(OFF_EVENTS) && (period_end & chan_en) == '0) |=>
      (pend == '0));

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend != '0 && mask != '0));

  assert_rd_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

endmodule

bind pwmc_ctrl pwmc_ctrl_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .wr_bits    (wr_bits),
  .period_end (period_end),
  .rd_valid   (rd_valid),
  .chan_en    (chan_en),
  .irq        (irq),
  .pend       (pend_q),
  .mask       (mask_q)
);

// File: tb/pwmc_ctrl_tb.sv
`timescale 1ns/1ps
module pwmc_ctrl_tb;

  localparam int NUM_CH = 4;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [NUM_CH-1:0] wr_bits = '0;
  logic [NUM_CH-1:0] period_end = '0;
  logic [DATA_W-1:0] rdata;
  logic              rd_valid;
  logic [NUM_CH-1:0] chan_en;
  logic              irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwmc_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_bits(wr_bits), .period_end(period_end), .rdata(rdata),
    .rd_valid(rd_valid), .chan_en(chan_en), .irq(irq)
  );

  // op: 0 = events only, 1 = write, 2 = read and compare rdata
  localparam int NV = 20;
  localparam logic [49:0] TBL [0:NV-1] = '{
    {2'd1, 8'h04, 4'h5, 4'h0, 32'h0},   // R2 enable ch0, ch2
    {2'd2, 8'h0C, 4'h0, 4'h0, 32'h5},   // R4
    {2'd1, 8'h04, 4'h2, 4'h0, 32'h0},   // R2 zero bits keep state
    {2'd2, 8'h0C, 4'h0, 4'h0, 32'h7},
    {2'd1, 8'h08, 4'h1, 4'h0, 32'h0},   // R3 disable ch0
    {2'd2, 8'h0C, 4'h0, 4'h0, 32'h6},
    {2'd1, 8'h10, 4'hC, 4'h0, 32'h0},   // R5 mask set
    {2'd2, 8'h18, 4'h0, 4'h0, 32'hC},
    {2'd1, 8'h14, 4'h4, 4'h0, 32'h0},   // R5 mask clear
    {2'd2, 8'h18, 4'h0, 4'h0, 32'h8},
    {2'd0, 8'h00, 4'h0, 4'hF, 32'h0},   // R6 pulses on all, ch1/ch2 enabled
    {2'd2, 8'h1C, 4'h0, 4'h0, 32'h6},   // R7
    {2'd2, 8'h1C, 4'h0, 4'h0, 32'h0},   // R7 cleared
    {2'd1, 8'h00, 4'hF, 4'h0, 32'h0},   // R10 mode write
    {2'd2, 8'h00, 4'h0, 4'h0, 32'h0},   // R10 mode reads zero
    {2'd1, 8'h0C, 4'h9, 4'h0, 32'h0},   // R10 read-only
    {2'd1, 8'h18, 4'h7, 4'h0, 32'h0},   // R10 read-only
    {2'd2, 8'h0C, 4'h0, 4'h0, 32'h6},
    {2'd2, 8'h18, 4'h0, 4'h0, 32'h8},
    {2'd2, 8'h2C, 4'h0, 4'h0, 32'h0}    // R10 unmapped
  };

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; drives for one cycle, returns at the next falling edge.
  task automatic step(input logic [1:0] op, input logic [7:0] a,
                      input logic [3:0] wb, input logic [3:0] ev);
    wr_en = (op == 2'd1);
    rd_en = (op == 2'd2);
    addr = a;
    wr_bits = wb;
    period_end = ev;
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
    wr_bits = '0;
    period_end = '0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a,
                          input logic [DATA_W-1:0] exp);
    step(2'd2, a, 4'h0, 4'h0);
    check(req, rdata, exp);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 reset enables", DATA_W'(chan_en), '0);
    check("R1 reset irq", DATA_W'(irq), '0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_check("R1 state after reset", 8'h0C, '0);
    check("R11 rd_valid", DATA_W'(rd_valid), 32'h1);
    rd_check("R1 mask after reset", 8'h18, '0);
    rd_check("R1 events after reset", 8'h1C, '0);

    for (int i = 0; i < NV; i++) begin
      logic [49:0] v;
      v = TBL[i];
      step(v[49:48], v[47:40], v[39:36], v[35:32]);
      if (v[49:48] == 2'd2) begin
        check($sformatf("R4/R5/R7/R10 vector %0d rdata", i), rdata, v[31:0]);
        check($sformatf("R11 vector %0d rd_valid", i), DATA_W'(rd_valid), 32'h1);
      end
    end
    check("R2/R3 chan_en pins", DATA_W'(chan_en), 32'h6);

    // R11: rd_valid drops without a read, data held
    @(negedge clk);
    check("R11 rd_valid low when idle", DATA_W'(rd_valid), '0);
    check("R11 rdata held", rdata, '0);

    // R9: masked-in channel raises irq
    step(2'd1, 8'h04, 4'h8, 4'h0);
    check("R9 irq low with nothing pending", DATA_W'(irq), '0);
    step(2'd0, 8'h00, 4'h0, 4'h8);
    check("R9 irq high on masked pending", DATA_W'(irq), 32'h1);
    rd_check("R7 read ch3 event", 8'h1C, 32'h8);
    check("R9 irq low after ack", DATA_W'(irq), '0);

    // R6: disabled channel ignored
    step(2'd0, 8'h00, 4'h0, 4'h1);
    rd_check("R6 disabled ch0 ignored", 8'h1C, '0);

    // R8: event in the same cycle as the acknowledging read
    step(2'd2, 8'h1C, 4'h0, 4'h2);
    check("R8 new event not in returned word", rdata, '0);
    check("R9 masked-out pending keeps irq low", DATA_W'(irq), '0);
    rd_check("R8 new event still pending", 8'h1C, 32'h2);
    step(2'd0, 8'h00, 4'h0, 4'h8);
    step(2'd2, 8'h1C, 4'h0, 4'h8);
    check("R8 returned old ch3 event", rdata, 32'h8);
    check("R9 irq stays on re-pended ch3", DATA_W'(irq), 32'h1);
    rd_check("R8 ch3 pending again", 8'h1C, 32'h8);

    // R10: write to event register changes nothing
    step(2'd0, 8'h00, 4'h0, 4'h4);
    step(2'd1, 8'h1C, 4'hF, 4'h0);
    rd_check("R10 event write ignored", 8'h1C, 32'h4);

    // R1: reset mid-run
    step(2'd0, 8'h00, 4'h0, 4'h8);
    check("R9 irq before reset", DATA_W'(irq), 32'h1);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq after reset", DATA_W'(irq), '0);
    check("R1 chan_en after reset", DATA_W'(chan_en), '0);
    rd_check("R1 mask cleared", 8'h18, '0);
    rd_check("R1 events cleared", 8'h1C, '0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule